// File: doc/BRIEF.md
# Three-Wire Serial Control Register

This block is a write-only serial slave that receives configuration from a host over three wires: a serial clock, a data line and an active-low enable. While the enable is low, each rising serial clock edge moves one data bit into a shift register, most significant bit first. When the enable returns high, the block copies the shift register into one of two stored control words. The last bit shifted in is the address bit, and it picks which word is written.

All three serial pins are asynchronous to the system clock. They pass through a synchronizer chain of parameterised depth before any edge detection. The stored words drive decoded field outputs:

- Word 1 (the channel word): reference divider select, swallow count, main count, oscillator select, deviation step, charge-pump code and its signed step value, and a transmit-filter enable.
- Word 2 (the setup word): PA level, a 5-bit DAC code and a 3-bit test code.

The block computes no analog meaning for any of these fields.

Top module: `ctl3w_regs`

## Requirements
- R1: While enable is low, each rising serial clock edge shifts the data bit into the least significant end of a 24-bit frame. The first bit sent therefore ends up in frame bit 23, and the final bit in frame bit 0.
- R2: A low-to-high enable transition stores frame bits 23..1 (data bits D22..D0) into one word, chosen by frame bit 0. A 0 selects word 1 and a 1 selects word 2. The word not selected keeps its value.
- R3: Only the 24 most recent bits are kept. Bits sent before them in the same transfer are dropped without any error indication.
- R4: The number of clock pulses is not checked. A short transfer shifts the earlier frame contents upward. An enable pulse with no clocks at all re-stores the current frame.
- R5: Serial clock edges while enable is high do not change the frame.
- R6: The outputs change only after an enable rise. While a transfer is in progress, they keep their previous values.
- R7: Word 1 decodes as follows:
  - D22: reference select
  - D21..D17: swallow count
  - D16..D13: main count
  - D12: oscillator select
  - D9..D7: deviation step
  - D2..D1: charge-pump code
  - D0: filter enable
- R8: Word 2 decodes as follows:
  - D12..D11: PA level
  - D10..D6: DAC code
  - D2..D0: test code

  D5..D3 have no effect on any output.
- R9: The signed 3-bit charge-pump step output maps code 00 to -1, 01 to 0, 10 to +1 and 11 to +2.
- R10: After a synchronous reset, both words are zero, so every field output reads zero and the charge-pump step reads -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en_n | input | 1 | Serial enable, active low, asynchronous |
| ref_sel | output | 1 | Reference divider select (word 1 D22) |
| swallow | output | 5 | Swallow count (word 1 D21..D17) |
| main_cnt | output | 4 | Main count code (word 1 D16..D13) |
| osc_sel | output | 1 | Oscillator select (word 1 D12) |
| dev_step | output | 3 | Deviation step (word 1 D9..D7) |
| cp_code | output | 2 | Charge-pump code (word 1 D2..D1) |
| cp_step | output | 3 | Signed charge-pump step, -1 to +2 |
| filt_en | output | 1 | Transmit filter enable (word 1 D0) |
| pa_lvl | output | 2 | PA level (word 2 D12..D11) |
| dac_code | output | 5 | DAC code (word 2 D10..D6) |
| test_code | output | 3 | Test code (word 2 D2..D0) |

## Verification
The bench builds the block with a three-stage synchronizer rather than the default two. Every serial phase is held for several system cycles, so each pin crosses a longer chain, and the edge detectors must still see each serial clock and enable edge exactly once. Under this deeper latency, the bench exercises:

- oversized and short transfers, and a transfer with no clocks at all;
- clocks sent while enable is high;
- all four charge-pump codes;
- outputs sampled in the middle of a transfer, which must still show the previous word values.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int FRAME_W = 24;
    localparam int WORD_W  = FRAME_W - 1;

    typedef struct packed {
        logic       ref_sel;
        logic [4:0] swallow;
        logic [3:0] main_cnt;
        logic       osc_sel;
        logic [2:0] dev_step;
        logic [1:0] cp_code;
        logic       filt_en;
    } chan_cfg_t;

    typedef struct packed {
        logic [1:0] pa_lvl;
        logic [4:0] dac_code;
        logic [2:0] test_code;
    } setup_cfg_t;

    function automatic chan_cfg_t decode_chan(input logic [WORD_W-1:0] d);
        chan_cfg_t c;
        c.ref_sel  = d[22];
        c.swallow  = d[21:17];
        c.main_cnt = d[16:13];
        c.osc_sel  = d[12];
        c.dev_step = d[9:7];
        c.cp_code  = d[2:1];
        c.filt_en  = d[0];
        return c;
    endfunction

    function automatic setup_cfg_t decode_setup(input logic [WORD_W-1:0] d);
        setup_cfg_t s;
        s.pa_lvl    = d[12:11];
        s.dac_code  = d[10:6];
        s.test_code = d[2:0];
        return s;
    endfunction

    function automatic logic signed [2:0] cp_to_step(input logic [1:0] code);
        return $signed({1'b0, code}) - 3'sd1;
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int           STAGES  = 2,
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         pipe[g] <= RST_VAL;
                else if (g == 0) pipe[g] <= din;
                else             pipe[g] <= pipe[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
    import ctl3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               s_clk,
    input  logic               s_dat,
    input  logic               s_en_n,
    output logic               load,
    output logic [FRAME_W-1:0] frame
);
    logic clk_q;
    logic en_q;
    logic bit_edge;

    assign bit_edge = s_clk & ~clk_q & ~s_en_n;
    assign load     = s_en_n & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            en_q  <= 1'b1;
            frame <= '0;
        end else begin
            clk_q <= s_clk;
            en_q  <= s_en_n;
            if (bit_edge) frame <= {frame[FRAME_W-2:0], s_dat};
        end
    end

    // R5: frame frozen while enable is high
    a_r5_idle_frame: assert property (@(posedge clk) disable iff (rst)
        s_en_n |=> $stable(frame));

    // R1: without a serial clock rise nothing shifts
    a_r1_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
        !(s_clk && !clk_q) |=> $stable(frame));
endmodule

// File: rtl/ctl3w_bank.sv
module ctl3w_bank
    import ctl3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output chan_cfg_t          chan,
    output setup_cfg_t         setup
);
    logic [WORD_W-1:0] word1_q;
    logic [WORD_W-1:0] word2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word1_q <= '0;
            word2_q <= '0;
        end else if (load) begin
            if (frame[0]) word2_q <= frame[FRAME_W-1:1];
            else          word1_q <= frame[FRAME_W-1:1];
        end
    end

    always_comb begin
        chan  = decode_chan(word1_q);
        setup = decode_setup(word2_q);
    end

    // R6: words change only on a load
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word1_q) && $stable(word2_q));

    // R2: address 0 writes word 1 and spares word 2
    a_r2_to_word1: assert property (@(posedge clk) disable iff (rst)
        load && !frame[0] |=> (word1_q == $past(frame[FRAME_W-1:1])) && $stable(word2_q));

    // R2: address 1 writes word 2 and spares word 1
    a_r2_to_word2: assert property (@(posedge clk) disable iff (rst)
        load && frame[0] |=> (word2_q == $past(frame[FRAME_W-1:1])) && $stable(word1_q));
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en_n,
    output logic              ref_sel,
    output logic [4:0]        swallow,
    output logic [3:0]        main_cnt,
    output logic              osc_sel,
    output logic [2:0]        dev_step,
    output logic [1:0]        cp_code,
    output logic signed [2:0] cp_step,
    output logic              filt_en,
    output logic [1:0]        pa_lvl,
    output logic [4:0]        dac_code,
    output logic [2:0]        test_code
);
    logic [2:0]         pins_s;
    logic               load;
    logic [FRAME_W-1:0] frame;
    chan_cfg_t          chan;
    setup_cfg_t         setup;

    // pin order {enable, data, clock}; enable idles high
    ctl3w_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_en_n, ser_dat, ser_clk}),
        .dout (pins_s)
    );

    ctl3w_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .s_clk  (pins_s[0]),
        .s_dat  (pins_s[1]),
        .s_en_n (pins_s[2]),
        .load   (load),
        .frame  (frame)
    );

    ctl3w_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .frame (frame),
        .chan  (chan),
        .setup (setup)
    );

    always_comb begin
        ref_sel   = chan.ref_sel;
        swallow   = chan.swallow;
        main_cnt  = chan.main_cnt;
        osc_sel   = chan.osc_sel;
        dev_step  = chan.dev_step;
        cp_code   = chan.cp_code;
        cp_step   = cp_to_step(chan.cp_code);
        filt_en   = chan.filt_en;
        pa_lvl    = setup.pa_lvl;
        dac_code  = setup.dac_code;
        test_code = setup.test_code;
    end

    // R9: step range is -1..+2
    a_r9_step_range: assert property (@(posedge clk) disable iff (rst)
        (cp_step >= -3'sd1) && (cp_step <= 3'sd2));
endmodule

// File: tb/tb_ctl3w_regs.sv
module tb_ctl3w_regs;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_en_n = 1'b1;
    logic              ref_sel, osc_sel, filt_en;
    logic [4:0]        swallow, dac_code;
    logic [3:0]        main_cnt;
    logic [2:0]        dev_step, test_code;
    logic [1:0]        cp_code, pa_lvl;
    logic signed [2:0] cp_step;

    always #2 clk = ~clk;

    ctl3w_regs #(.SYNC_STAGES(3)) dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
        .ref_sel(ref_sel), .swallow(swallow), .main_cnt(main_cnt), .osc_sel(osc_sel),
        .dev_step(dev_step), .cp_code(cp_code), .cp_step(cp_step), .filt_en(filt_en),
        .pa_lvl(pa_lvl), .dac_code(dac_code), .test_code(test_code)
    );

    typedef struct {
        logic [22:0] w1;
        logic [22:0] w2;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [23:0] m_frame = '0;
    logic [22:0] e_w1 = '0;
    logic [22:0] e_w2 = '0;
    bit          done = 0;

    task automatic push(input string tag);
        exp_t e;
        e.w1 = e_w1; e.w2 = e_w2; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send n bits, MSB of the n first; optionally probe outputs mid-transfer (R6)
    task automatic send(input logic [63:0] bits, input int n, input string tag);
        @(negedge clk) ser_en_n = 1'b0;
        wait_cyc(6);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            wait_cyc(3);
            ser_clk = 1'b1;
            m_frame = {m_frame[22:0], bits[i]};
            wait_cyc(3);
            ser_clk = 1'b0;
            if (i == n / 2 && n > 4) begin
                wait_cyc(8);
                push("R6 outputs held mid-transfer");
            end
        end
        wait_cyc(4);
        ser_en_n = 1'b1;
        if (m_frame[0]) e_w2 = m_frame[23:1];
        else            e_w1 = m_frame[23:1];
        wait_cyc(12);
        push(tag);
        wait_cyc(6);
    endtask

    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = i[0];
            wait_cyc(3);
            ser_clk = 1'b1;
            wait_cyc(3);
            ser_clk = 1'b0;
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                logic [26:0] act, exp;
                logic signed [2:0] es;
                e = q.pop_front();
                act = {ref_sel, swallow, main_cnt, osc_sel, dev_step, cp_code, filt_en,
                       pa_lvl, dac_code, test_code};
                exp = {e.w1[22], e.w1[21:17], e.w1[16:13], e.w1[12], e.w1[9:7], e.w1[2:1],
                       e.w1[0], e.w2[12:11], e.w2[10:6], e.w2[2:0]};
                n_cmp++;
                if (act !== exp) begin
                    n_bad++;
                    $display("FAIL %s (R7/R8 fields): actual %h expected %h", e.tag, act, exp);
                end
                case (e.w1[2:1])
                    2'b00:   es = -3'sd1;
                    2'b01:   es = 3'sd0;
                    2'b10:   es = 3'sd1;
                    default: es = 3'sd2;
                endcase
                n_cmp++;
                if (cp_step !== es) begin
                    n_bad++;
                    $display("FAIL %s (R9 step): actual %0d expected %0d", e.tag, cp_step, es);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        push("R10 reset state");
        // R1 R7: word 1 full frame, addr 0
        send({40'd0, 23'h5A_C3B5, 1'b0}, 24, "R1 R7 word1 load");
        // R2 R8: word 2, word 1 must stay
        send({40'd0, 23'h00_1B6D, 1'b1}, 24, "R2 R8 word2 load");
        // R8: bits D5..D3 don't-care, set them
        send({40'd0, 23'h00_0838, 1'b1}, 24, "R8 don't-care bits");
        // R3: six surplus leading ones
        send({34'd0, 6'b111111, 23'h2A_5552, 1'b0}, 30, "R3 surplus leading bits");
        // R4: short transfer, five bits
        send({59'd0, 5'b10110}, 5, "R4 short transfer");
        // R5: clocks while enable high then zero-clock pulse re-stores frame (R4)
        idle_clocks(7);
        send(64'd0, 0, "R5 R4 idle clocks, zero-clock latch");
        // R9: all charge-pump codes
        for (int c = 0; c < 4; c++) begin
            logic [22:0] d;
            d = 23'h41_0000 | (23'(c) << 1);
            send({40'd0, d, 1'b0}, 24, "R9 cp code sweep");
        end
        wait (q.size() == 0);
        wait_cyc(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule